// File: doc/BRIEF.md
# Pipelined Byte Zero-Compaction Shifter

This block takes a record made of a fixed group of always-present bytes plus a set of optional extra bytes. An occupancy map marks which of the optional byte slots actually carry data. The block squeezes the occupied extras down toward slot 0 so that they form one gap-free run, in the same order they arrived. It also reports how many of them there are, so that a later packing stage can append exactly that many bytes behind the fixed group.

The compaction runs as a chain of identical register stages, one stage per optional slot. Each stage inspects a single map bit. When that slot is empty, the stage drops it by moving every byte above it down one position. The fixed bytes, a valid flag and an empty-bunch flag pass through a delay line of the same length. Every record therefore leaves the block intact and aligned, a fixed number of clocks after it entered. A new record can be accepted on every clock.

Top module: `slot_compact_pipe`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every output is zero, including valid, the empty flag, the count and all data bytes.
- R2: A record presented with valid high on a clock edge appears on the outputs exactly 8 clocks later, with out_valid high. Records may arrive on consecutive clocks and leave on consecutive clocks. No output record appears without a matching input record.
- R3: Optional slot i is the byte at bits [8i+7:8i] of in_long, and map bit i set means that slot is occupied. The occupied bytes leave at output positions 0, 1, 2 and so on, in ascending slot order. Output position p is bits [8p+7:8p] of out_long.
- R4: out_count equals the number of set bits in the map of the same record, which is a value from 0 to 8.
- R5: Every output position at or above out_count is zero, whatever the unoccupied input slots contained.
- R6: out_fixed equals the in_fixed value of the same record, bit for bit.
- R7: out_empty equals the in_empty value of the same record.
- R8: An all-empty map yields a count of 0 and all-zero out_long. An all-occupied map yields a count of 8 and out_long equal to in_long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record present on the inputs |
| in_empty | input | 1 | Empty-bunch marker carried with the record |
| in_map | input | 8 | Occupancy map, one bit per optional slot |
| in_long | input | 64 | Optional slot bytes, slot i in bits [8i+7:8i] |
| in_fixed | input | 64 | Fixed-format bytes, passed through delayed |
| out_valid | output | 1 | Compacted record present on the outputs |
| out_empty | output | 1 | Delayed empty-bunch marker |
| out_count | output | 4 | Number of valid compacted bytes |
| out_long | output | 64 | Compacted bytes, position 0 lowest, zero above the count |
| out_fixed | output | 64 | Delayed fixed-format bytes |

## Verification
Each output of a record is due 8 clocks after the edge that captured its input: the compacted bytes, the count, the fixed bytes and the empty flag. Nothing a record produces is visible earlier. The driver stamps each expected item with the clock count at the time it is issued. When out_valid is seen, the monitor pops the oldest item and requires the elapsed count to be exactly 8. It then compares every field, so a slip of one cycle in any field, or a missing or extra record, is reported. Back-to-back records, random gaps, and the all-empty and all-full maps exercise the ordering and zero-fill rules.

// File: rtl/slot_compact_pkg.sv
package slot_compact_pkg;
  // width of a counter that must hold values 0..n
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/hdr_delay.sv
module hdr_delay #(
  parameter int W     = 64,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] tap;

  always_ff @(posedge clk) begin
    if (rst) tap[0] <= '0;
    else     tap[0] <= d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap[i] <= '0;
      else     tap[i] <= tap[i-1];
    end
  end

  assign q = tap[DEPTH-1];

  // R6
  first_tap_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tap[0] == $past(d));
endmodule

// File: rtl/compact_step.sv
module compact_step
  import slot_compact_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int BYTE_W = 8,
  parameter int STEP   = 0,
  parameter int CW     = cnt_w(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          valid_i,
  input  logic                          empty_i,
  input  logic [SLOTS-1:0]              map_i,
  input  logic [CW-1:0]                 count_i,
  input  logic [SLOTS-1:0][BYTE_W-1:0]  data_i,
  output logic                          valid_o,
  output logic                          empty_o,
  output logic [SLOTS-1:0]              map_o,
  output logic [CW-1:0]                 count_o,
  output logic [SLOTS-1:0][BYTE_W-1:0]  data_o
);
  // stages walk the slots from the top down, so lower slots never move early
  localparam int J = SLOTS - 1 - STEP;

  logic [SLOTS-1:0][BYTE_W-1:0] shifted;

  always_comb begin
    shifted = data_i;
    if (!map_i[J]) begin
      for (int p = 0; p < SLOTS - 1; p++) begin
        if (p >= J) shifted[p] = data_i[p+1];
      end
      shifted[SLOTS-1] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      empty_o <= 1'b0;
      map_o   <= '0;
      count_o <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      empty_o <= empty_i;
      map_o   <= map_i;
      count_o <= count_i + CW'(map_i[J]);
      data_o  <= shifted;
    end
  end

  // R2
  step_valid_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> valid_o == $past(valid_i));
  // R3
  occupied_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && map_i[J]) |=> data_o[J] == $past(data_i[J]));
  // R5
  top_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !map_i[J]) |=> data_o[SLOTS-1] == '0);
  // R7
  empty_carry_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> empty_o == $past(empty_i));
endmodule

// File: rtl/slot_compact_pipe.sv
module slot_compact_pipe
  import slot_compact_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int BYTE_W = 8,
  parameter int FIXED  = 8,
  parameter int CW     = cnt_w(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_empty,
  input  logic [SLOTS-1:0]          in_map,
  input  logic [SLOTS*BYTE_W-1:0]   in_long,
  input  logic [FIXED*BYTE_W-1:0]   in_fixed,
  output logic                      out_valid,
  output logic                      out_empty,
  output logic [CW-1:0]             out_count,
  output logic [SLOTS*BYTE_W-1:0]   out_long,
  output logic [FIXED*BYTE_W-1:0]   out_fixed
);
  localparam int FW = FIXED * BYTE_W;

  logic [SLOTS:0]                          v_s, e_s;
  logic [SLOTS:0][SLOTS-1:0]               m_s;
  logic [SLOTS:0][CW-1:0]                  c_s;
  logic [SLOTS:0][SLOTS-1:0][BYTE_W-1:0]   d_s;

  assign v_s[0] = in_valid;
  assign e_s[0] = in_empty;
  assign m_s[0] = in_map;
  assign c_s[0] = '0;
  assign d_s[0] = in_long;

  for (genvar s = 0; s < SLOTS; s++) begin : g_step
    compact_step #(
      .SLOTS (SLOTS),
      .BYTE_W(BYTE_W),
      .STEP  (s),
      .CW    (CW)
    ) u_step (
      .clk    (clk),
      .rst    (rst),
      .valid_i(v_s[s]),
      .empty_i(e_s[s]),
      .map_i  (m_s[s]),
      .count_i(c_s[s]),
      .data_i (d_s[s]),
      .valid_o(v_s[s+1]),
      .empty_o(e_s[s+1]),
      .map_o  (m_s[s+1]),
      .count_o(c_s[s+1]),
      .data_o (d_s[s+1])
    );
  end

  hdr_delay #(.W(FW), .DEPTH(SLOTS)) u_hdr (
    .clk(clk),
    .rst(rst),
    .d  (in_fixed),
    .q  (out_fixed)
  );

  assign out_valid = v_s[SLOTS];
  assign out_empty = e_s[SLOTS];
  assign out_count = c_s[SLOTS];
  assign out_long  = d_s[SLOTS];

  logic tail_ok;
  always_comb begin
    tail_ok = 1'b1;
    for (int p = 0; p < SLOTS; p++) begin
      if (p >= int'(out_count) && d_s[SLOTS][p] != '0) tail_ok = 1'b0;
    end
  end

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> int'(out_count) <= SLOTS);
  // R4
  count_pop_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> int'(out_count) == $countones(m_s[SLOTS]));
  // R5
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> tail_ok);
endmodule

// File: tb/slot_compact_pipe_tb.sv
`timescale 1ns/1ps
module slot_compact_pipe_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_empty = 1'b0;
  logic [7:0]  in_map = '0;
  logic [63:0] in_long = '0;
  logic [63:0] in_fixed = '0;
  logic        out_valid, out_empty;
  logic [3:0]  out_count;
  logic [63:0] out_long, out_fixed;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          stamp;
    logic [3:0]  cnt;
    logic [63:0] lng;
    logic [63:0] fix;
    logic        emp;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slot_compact_pipe u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_empty(in_empty), .in_map(in_map),
    .in_long(in_long), .in_fixed(in_fixed),
    .out_valid(out_valid), .out_empty(out_empty), .out_count(out_count),
    .out_long(out_long), .out_fixed(out_fixed)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input bit v, input bit e, input logic [7:0] m,
                      input logic [63:0] l, input logic [63:0] f);
    exp_t x;
    int k;
    @(negedge clk);
    in_valid = v; in_empty = e; in_map = m; in_long = l; in_fixed = f;
    if (v) begin
      x.lng = '0; k = 0;
      for (int i = 0; i < 8; i++) begin
        if (m[i]) begin
          x.lng[8*k +: 8] = l[8*i +: 8];
          k++;
        end
      end
      x.cnt = 4'(k); x.fix = f; x.emp = e; x.stamp = cyc;
      sb.push_back(x);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected record", 64'(out_valid), 64'd0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        check(cyc - x.stamp == 8, "R2 latency", 64'(cyc - x.stamp), 64'd8);
        check(out_long == x.lng, "R3/R5 compacted bytes", out_long, x.lng);
        check(out_count == x.cnt, "R4 count", 64'(out_count), 64'(x.cnt));
        check(out_fixed == x.fix, "R6 fixed bytes", out_fixed, x.fix);
        check(out_empty == x.emp, "R7 empty flag", 64'(out_empty), 64'(x.emp));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    check(out_valid == 0 && out_empty == 0 && out_count == 0, "R1 flags", {out_valid, out_empty, out_count}, 64'd0);
    check(out_long == 0 && out_fixed == 0, "R1 data", out_long | out_fixed, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && out_long == 0 && out_fixed == 0, "R1 after release", out_long, 64'd0);
    // R8: all-empty and all-full maps, back to back (R2)
    send(1, 0, 8'h00, 64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444);
    send(1, 1, 8'hFF, 64'h0807_0605_0403_0201, 64'h5555_6666_7777_8888);
    send(1, 0, 8'h01, 64'hFFFF_FFFF_FFFF_FFAA, 64'h0);
    send(1, 0, 8'h80, 64'hBB11_2233_4455_6677, 64'h1);
    send(1, 1, 8'hA5, 64'h8877_6655_4433_2211, 64'h2);
    send(1, 0, 8'h5A, 64'h8877_6655_4433_2211, 64'h3);
    // R3..R7: random maps, random gaps
    for (int n = 0; n < 400; n++) begin
      send(($urandom % 5) != 0, $urandom % 2, 8'($urandom),
           {$urandom, $urandom}, {$urandom, $urandom});
    end
    send(0, 0, 8'h00, 64'h0, 64'h0);
    repeat (12) @(negedge clk);
    // R2: every issued record came out
    check(sb.size() == 0, "R2 drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule